// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block decides, once per clock, where a 32-bit load/store processor fetches its next instruction. It receives the current program counter, the decoded instruction fields (major opcode, second source register number, destination register number, function code and the 16-bit immediate) and the two values read from the register file. It produces the following program counter and, for the jump-and-link-register instruction, a request to write the return address into the register file.

Four kinds of control flow are handled. The first is sequential advance by one 4-byte instruction. The second is a pair of conditional branches: equality of two registers, and a non-negative test of one signed register. Both branch targets are relative to the following instruction, with an offset counted in words. The third is the register-indirect jump. The fourth is the register-indirect jump that also links. Every output is registered, so the results for the inputs presented at one rising edge appear after that edge and hold until the next edge. A fetch stage takes `next_pc_o` as its new PC. A write-back stage takes the link triple.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `next_pc_o` = RESET_PC (default 0), with `link_we_o`, `link_reg_o`, `link_val_o` and `misalign_o` all 0. Outside reset, each output reflects the inputs sampled at the previous rising edge.
- R2: An opcode other than 0x04 or 0x01, and opcode 0 with a function code other than 0x08 or 0x09, gives `next_pc_o` = PC+4. The sum wraps modulo 2^32 and no link is requested.
- R3: Opcode 0x04 compares the two register values. If they are equal, `next_pc_o` = PC + 4 + 4 × sign-extended immediate, modulo 2^32. If they differ, `next_pc_o` = PC+4.
- R4: Opcode 0x01 with rt field = 1 treats `rs_val_i` as a signed number. If it is ≥ 0, `next_pc_o` = PC + 4 + 4 × sign-extended immediate. If it is negative, `next_pc_o` = PC+4.
- R5: Opcode 0x01 with any rt field other than 1 behaves as sequential advance (PC+4, no link).
- R6: Opcode 0 with function code 0x08 gives `next_pc_o` = `rs_val_i`, with all 32 bits passed unchanged, including the two low bits.
- R7: Opcode 0 with function code 0x09 gives `next_pc_o` = `rs_val_i` and `link_we_o` = 1, with `link_val_o` = PC+8 modulo 2^32. `link_reg_o` is the rd field, or 31 when the rd field is 0. A link therefore never targets register 0.
- R8: `link_we_o` is 1 only for the function code 0x09 case. Whenever `link_we_o` is 0, `link_reg_o` and `link_val_o` are 0.
- R9: `misalign_o` is 1 exactly when the instruction is a register-indirect jump (function code 0x08 or 0x09 under opcode 0) and bits [1:0] of `rs_val_i` are nonzero. In every other case it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_i | input | 32 | Program counter of the current instruction |
| opcode_i | input | 6 | Major opcode field |
| rt_i | input | 5 | Second source register number (selects the branch variant under opcode 0x01) |
| rd_i | input | 5 | Destination register number for the link |
| funct_i | input | 6 | Function code under opcode 0 |
| imm_i | input | 16 | Signed word offset for branches |
| rs_val_i | input | 32 | Value read from the first source register |
| rt_val_i | input | 32 | Value read from the second source register |
| next_pc_o | output | 32 | Registered next program counter |
| link_we_o | output | 1 | Registered request to write the link register |
| link_reg_o | output | 5 | Registered link destination register number |
| link_val_o | output | 32 | Registered return address |
| misalign_o | output | 1 | Registered flag: indirect target not word aligned |

## Verification
The assertions check on every cycle the properties that relate outputs to the inputs of the cycle before. A link is raised only for the linking jump, it never names register 0, and it carries PC+8. An untaken equality branch and any plain opcode advance by four. The misalignment flag appears only with an unaligned target. The bench scenarios have to show the exact branch target arithmetic: forward and backward offsets, the most negative and most positive immediates, and address wrap at the top of memory. They also show the rt-field discrimination under opcode 0x01, the signed boundary at zero and at the sign bit, the rd = 0 default to register 31, and the reset values, including a reset that arrives while a linking jump is being presented.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int OPC_W   = 6;
  localparam int FUNCT_W = 6;

  localparam logic [OPC_W-1:0]   OP_SPECIAL = 6'h00;
  localparam logic [OPC_W-1:0]   OP_REGIMM  = 6'h01;
  localparam logic [OPC_W-1:0]   OP_BRQ     = 6'h04;
  localparam logic [FUNCT_W-1:0] FN_JREG    = 6'h08;
  localparam logic [FUNCT_W-1:0] FN_JLINK   = 6'h09;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BRQ,
    FLOW_BNNEG,
    FLOW_JREG,
    FLOW_JLINK
  } flow_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [OPC_W-1:0]   opcode,
  input  logic [FUNCT_W-1:0] funct,
  input  logic [REG_AW-1:0]  rt,
  output flow_e              kind
);
  localparam logic [REG_AW-1:0] RT_NNEG = REG_AW'(1);

  always_comb begin
    kind = FLOW_SEQ;
    unique case (opcode)
      OP_BRQ:     kind = FLOW_BRQ;
      OP_REGIMM:  if (rt == RT_NNEG) kind = FLOW_BNNEG;
      OP_SPECIAL: begin
        if (funct == FN_JREG)       kind = FLOW_JREG;
        else if (funct == FN_JLINK) kind = FLOW_JLINK;
      end
      default:    kind = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  flow_e           kind,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            taken
);
  logic eq;
  logic nneg;

  assign eq   = (a == b);
  assign nneg = ~a[XLEN-1];

  always_comb begin
    case (kind)
      FLOW_BRQ:   taken = eq;
      FLOW_BNNEG: taken = nneg;
      default:    taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN        = 32,
  parameter int IMM_W       = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  br_pc,
  output logic [XLEN-1:0]  link_pc
);
  localparam int ALIGN_W = $clog2(INSTR_BYTES);

  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] offset;

  assign imm_sx  = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign offset  = imm_sx << ALIGN_W;
  assign seq_pc  = pc + XLEN'(INSTR_BYTES);
  assign br_pc   = seq_pc + offset;
  assign link_pc = pc + XLEN'(2 * INSTR_BYTES);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter int              REG_AW       = 5,
  parameter int              IMM_W        = 16,
  parameter int              INSTR_BYTES  = 4,
  parameter logic [XLEN-1:0] RESET_PC     = '0,
  parameter int              LINK_DEFAULT = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic [REG_AW-1:0]  rt_i,
  input  logic [REG_AW-1:0]  rd_i,
  input  logic [FUNCT_W-1:0] funct_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [XLEN-1:0]    rs_val_i,
  input  logic [XLEN-1:0]    rt_val_i,
  output logic [XLEN-1:0]    next_pc_o,
  output logic               link_we_o,
  output logic [REG_AW-1:0]  link_reg_o,
  output logic [XLEN-1:0]    link_val_o,
  output logic               misalign_o
);
  localparam int ALIGN_W = $clog2(INSTR_BYTES);
  localparam logic [REG_AW-1:0] LINK_DEF_R = REG_AW'(LINK_DEFAULT);

  flow_e           kind;
  logic            taken;
  logic [XLEN-1:0] seq_pc, br_pc, link_pc;
  logic [XLEN-1:0] npc_d;
  logic            we_d;
  logic [REG_AW-1:0] reg_d;
  logic [XLEN-1:0] val_d;
  logic            mis_d;
  logic            low_bits_set;

  npc_decode #(.REG_AW(REG_AW)) u_dec (
    .opcode (opcode_i),
    .funct  (funct_i),
    .rt     (rt_i),
    .kind   (kind)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind  (kind),
    .a     (rs_val_i),
    .b     (rt_val_i),
    .taken (taken)
  );

  npc_target #(.XLEN(XLEN), .IMM_W(IMM_W), .INSTR_BYTES(INSTR_BYTES)) u_tgt (
    .pc      (pc_i),
    .imm     (imm_i),
    .seq_pc  (seq_pc),
    .br_pc   (br_pc),
    .link_pc (link_pc)
  );

  generate
    if (ALIGN_W > 0) begin : g_align
      assign low_bits_set = |rs_val_i[ALIGN_W-1:0];
    end else begin : g_noalign
      assign low_bits_set = 1'b0;
    end
  endgenerate

  always_comb begin
    npc_d = seq_pc;
    we_d  = 1'b0;
    reg_d = '0;
    val_d = '0;
    mis_d = 1'b0;
    case (kind)
      FLOW_BRQ, FLOW_BNNEG: npc_d = taken ? br_pc : seq_pc;
      FLOW_JREG: begin
        npc_d = rs_val_i;
        mis_d = low_bits_set;
      end
      FLOW_JLINK: begin
        npc_d = rs_val_i;
        mis_d = low_bits_set;
        we_d  = 1'b1;
        reg_d = (rd_i == '0) ? LINK_DEF_R : rd_i;
        val_d = link_pc;
      end
      default: npc_d = seq_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc_o  <= RESET_PC;
      link_we_o  <= 1'b0;
      link_reg_o <= '0;
      link_val_o <= '0;
      misalign_o <= 1'b0;
    end else begin
      next_pc_o  <= npc_d;
      link_we_o  <= we_d;
      link_reg_o <= reg_d;
      link_val_o <= val_d;
      misalign_o <= mis_d;
    end
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5,
  parameter int IMM_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [XLEN-1:0]    pc_i,
  input logic [OPC_W-1:0]   opcode_i,
  input logic [FUNCT_W-1:0] funct_i,
  input logic [XLEN-1:0]    rs_val_i,
  input logic [XLEN-1:0]    rt_val_i,
  input logic [XLEN-1:0]    next_pc_o,
  input logic               link_we_o,
  input logic [REG_AW-1:0]  link_reg_o,
  input logic [XLEN-1:0]    link_val_o,
  input logic               misalign_o
);
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  a_r8_link_only_jlink: assert property (@(posedge clk) disable iff (rst)
    (primed && link_we_o) |-> $past(opcode_i == OP_SPECIAL && funct_i == FN_JLINK));

  a_r7_link_not_zero: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> (link_reg_o != '0));

  a_r7_link_value: assert property (@(posedge clk) disable iff (rst)
    (primed && link_we_o) |-> (link_val_o == $past(pc_i) + XLEN'(8)));

  a_r8_quiet_when_no_link: assert property (@(posedge clk) disable iff (rst)
    !link_we_o |-> (link_reg_o == '0 && link_val_o == '0));

  a_r9_misalign_low_bits: assert property (@(posedge clk) disable iff (rst)
    misalign_o |-> (next_pc_o[1:0] != 2'b00));

  a_r3_untaken_eq: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(opcode_i == OP_BRQ && rs_val_i != rt_val_i))
      |-> (next_pc_o == $past(pc_i) + XLEN'(4)));

  a_r2_plain_opcode: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(opcode_i != OP_SPECIAL && opcode_i != OP_REGIMM && opcode_i != OP_BRQ))
      |-> (next_pc_o == $past(pc_i) + XLEN'(4) && !link_we_o && !misalign_o));
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .REG_AW(REG_AW), .IMM_W(IMM_W)) i_npc_unit_chk (
  .clk        (clk),
  .rst        (rst),
  .pc_i       (pc_i),
  .opcode_i   (opcode_i),
  .funct_i    (funct_i),
  .rs_val_i   (rs_val_i),
  .rt_val_i   (rt_val_i),
  .next_pc_o  (next_pc_o),
  .link_we_o  (link_we_o),
  .link_reg_o (link_reg_o),
  .link_val_o (link_val_o),
  .misalign_o (misalign_o)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_i = '0;
  logic [5:0]  opcode_i = '0;
  logic [4:0]  rt_i = '0;
  logic [4:0]  rd_i = '0;
  logic [5:0]  funct_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [31:0] next_pc_o;
  logic        link_we_o;
  logic [4:0]  link_reg_o;
  logic [31:0] link_val_o;
  logic        misalign_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rst(rst), .pc_i(pc_i), .opcode_i(opcode_i), .rt_i(rt_i),
    .rd_i(rd_i), .funct_i(funct_i), .imm_i(imm_i), .rs_val_i(rs_val_i),
    .rt_val_i(rt_val_i), .next_pc_o(next_pc_o), .link_we_o(link_we_o),
    .link_reg_o(link_reg_o), .link_val_o(link_val_o), .misalign_o(misalign_o)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [5:0]  op;
    logic [4:0]  rt;
    logic [4:0]  rd;
    logic [5:0]  fn;
    logic [15:0] imm;
    logic [31:0] rsv;
    logic [31:0] rtv;
    logic [31:0] npc;
    logic        we;
    logic [4:0]  lreg;
    logic [31:0] lval;
    logic        mis;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{32'h100, 6'h08, 5'd0, 5'd0, 6'h00, 16'h0000, 32'h5, 32'h5, 32'h104, 1'b0, 5'd0, 32'h0, 1'b0},
    '{32'h100, 6'h04, 5'd9, 5'd0, 6'h00, 16'h0003, 32'h5, 32'h5, 32'h110, 1'b0, 5'd0, 32'h0, 1'b0},
    '{32'h100, 6'h04, 5'd9, 5'd0, 6'h00, 16'h0003, 32'h5, 32'h6, 32'h104, 1'b0, 5'd0, 32'h0, 1'b0},
    '{32'h1000, 6'h04, 5'd9, 5'd0, 6'h00, 16'hFFD6, 32'hA, 32'hA, 32'hF5C, 1'b0, 5'd0, 32'h0, 1'b0},
    '{32'h40000, 6'h04, 5'd9, 5'd0, 6'h00, 16'h8000, 32'h0, 32'h0, 32'h20004, 1'b0, 5'd0, 32'h0, 1'b0},
    '{32'h200, 6'h01, 5'd1, 5'd0, 6'h00, 16'h0002, 32'h0, 32'h0, 32'h20C, 1'b0, 5'd0, 32'h0, 1'b0},
    '{32'h200, 6'h01, 5'd1, 5'd0, 6'h00, 16'h0002, 32'h80000000, 32'h0, 32'h204, 1'b0, 5'd0, 32'h0, 1'b0},
    '{32'h0, 6'h01, 5'd1, 5'd0, 6'h00, 16'h7FFF, 32'h7FFFFFFF, 32'h0, 32'h20000, 1'b0, 5'd0, 32'h0, 1'b0},
    '{32'h200, 6'h01, 5'd0, 5'd0, 6'h00, 16'h0002, 32'h5, 32'h0, 32'h204, 1'b0, 5'd0, 32'h0, 1'b0},
    '{32'h200, 6'h01, 5'd3, 5'd0, 6'h00, 16'h0002, 32'h5, 32'h0, 32'h204, 1'b0, 5'd0, 32'h0, 1'b0},
    '{32'h300, 6'h00, 5'd0, 5'd0, 6'h08, 16'h0000, 32'h00400020, 32'h0, 32'h00400020, 1'b0, 5'd0, 32'h0, 1'b0},
    '{32'h300, 6'h00, 5'd0, 5'd0, 6'h08, 16'h0000, 32'h00400022, 32'h0, 32'h00400022, 1'b0, 5'd0, 32'h0, 1'b1},
    '{32'h300, 6'h00, 5'd0, 5'd9, 6'h09, 16'h0000, 32'h800, 32'h0, 32'h800, 1'b1, 5'd9, 32'h308, 1'b0},
    '{32'h300, 6'h00, 5'd0, 5'd0, 6'h09, 16'h0000, 32'h801, 32'h0, 32'h801, 1'b1, 5'd31, 32'h308, 1'b1},
    '{32'h300, 6'h00, 5'd0, 5'd4, 6'h20, 16'h0000, 32'h800, 32'h0, 32'h304, 1'b0, 5'd0, 32'h0, 1'b0},
    '{32'hFFFFFFFC, 6'h00, 5'd0, 5'd2, 6'h09, 16'h0000, 32'h40, 32'h0, 32'h40, 1'b1, 5'd2, 32'h4, 1'b0}
  };
  localparam string VTAG [NV] = '{
    "R2 plain opcode", "R3 equal taken", "R3 unequal", "R3 backward offset",
    "R3 most negative offset", "R4 zero taken", "R4 sign bit untaken", "R4 largest offset",
    "R5 rt=0", "R5 rt=3", "R6 aligned", "R9 unaligned jump",
    "R7 explicit rd", "R7 rd=0 to 31", "R8 add function code", "R7 link wrap"
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    pc_i = v.pc; opcode_i = v.op; rt_i = v.rt; rd_i = v.rd; funct_i = v.fn;
    imm_i = v.imm; rs_val_i = v.rsv; rt_val_i = v.rtv;
  endtask

  task automatic check_all(input string tag, input vec_t v);
    check(tag, "next_pc", next_pc_o, v.npc);
    check(tag, "link_we", {31'b0, link_we_o}, {31'b0, v.we});
    check(tag, "link_reg", {27'b0, link_reg_o}, {27'b0, v.lreg});
    check(tag, "link_val", link_val_o, v.lval);
    check(tag, "misalign", {31'b0, misalign_o}, {31'b0, v.mis});
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    vec_t rv;
    rv = '0;
    repeat (3) @(negedge clk);
    check_all("R1 reset state", rv);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      check_all(VTAG[i], VEC[i]);
    end
    // Back-to-back: a one-cycle latency must follow each input change (R1)
    drive(VEC[1]);
    @(negedge clk);
    drive(VEC[12]);
    check_all("R1 back-to-back first", VEC[1]);
    @(negedge clk);
    check_all("R1 back-to-back second", VEC[12]);
    // Reset arriving while a linking jump is presented (R1)
    rst = 1'b1;
    @(negedge clk);
    check_all("R1 reset during link", rv);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 after reset release", VEC[12]);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule